// File: doc/BRIEF.md
# Row-Split Ping-Pong Frame Store

This block captures a raster-ordered pixel stream into on-chip storage so that a downstream sub-pixel interpolator can read four neighbouring pixels in one cycle. Each incoming pixel gets a row and column coordinate from two counters. A start-of-frame pulse returns the counters to the origin. The parity of the row picks the bank the pixel goes to, so two vertically adjacent pixels always sit in different banks. Each bank has two read ports, so two horizontally adjacent pixels from the same row can be fetched at once.

Storage is doubled. One half takes the frame that is arriving while the other half holds the last complete frame and serves reads only. When the final pixel of a frame is written, the halves exchange roles. A side indicator and a ready flag tell the reader which half holds valid data.

The frame geometry is parameterised. The defaults give a 32×32 frame. A 512×512 frame with 8-bit pixels uses column and row widths of 9 and a 17-bit bank address.

Top module: `rowSplitFrameStore`

## Requirements
- R1: After reset, `frameReady` is 0 and `readSide` is 1, so the first frame is written into side 0.
- R2: A pixel accepted with `newFrame` high is placed at row 0, column 0. A `newFrame` pulse with `pixValid` low clears the position, so the next accepted pixel lands at row 0, column 0.
- R3: Accepted pixels follow raster order. The column advances by one per pixel. After column COLS-1 it returns to 0 and the row advances by one, so pixel k of a frame sits at row k/COLS, column k%COLS.
- R4: Pixels on even rows are stored in the even bank and pixels on odd rows in the odd bank. The bank address is {row with its LSB removed, column}.
- R5: The clock edge that writes row ROWS-1, column COLS-1 also toggles `readSide`. From the next cycle, reads return the frame just completed.
- R6: `frameReady` stays 0 until the first full frame has been written. From then on it stays 1.
- R7: Each bank has two independent read ports. The data for an address presented before a clock edge appears on the port output after that edge, taken from the side given by `readSide` at that edge.
- R8: While `pixValid` is 0, nothing is written and the position is held, whatever `pixData` carries.
- R9: A `newFrame` pulse in the middle of a frame does not exchange sides. The frame is written again from the origin into the same side.
- R10: While a frame is being written, reads return the previously completed frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel present on `pixData` this cycle |
| newFrame | input | 1 | Start-of-frame pulse; restarts position at origin |
| pixData | input | PIX_W | Incoming pixel value |
| rdAddrEvenA | input | ROW_W-1+COL_W | Even bank, port A read address |
| rdAddrEvenB | input | ROW_W-1+COL_W | Even bank, port B read address |
| rdAddrOddA | input | ROW_W-1+COL_W | Odd bank, port A read address |
| rdAddrOddB | input | ROW_W-1+COL_W | Odd bank, port B read address |
| rdDataEvenA | output | PIX_W | Even bank, port A data (1-cycle latency) |
| rdDataEvenB | output | PIX_W | Even bank, port B data |
| rdDataOddA | output | PIX_W | Odd bank, port A data |
| rdDataOddB | output | PIX_W | Odd bank, port B data |
| readSide | output | 1 | Side currently holding the completed frame |
| frameReady | output | 1 | A complete frame is available for reads |

## Verification
A write takes effect at the clock edge where `pixValid` is high. A read address driven before an edge returns its data after that same edge, so the bench drives on falling edges and compares read data at the next falling edge. The side flip and the ready flag become visible after the edge that writes the last pixel, and the bench samples them at the falling edge that follows that write. Whole frames are swept with reads that run while the next frame is streaming in, including frames with idle gaps and frames restarted partway through, so every bank location is compared against a value computed from frame number, row and column.

// File: rtl/rsfs_pkg.sv
package rsfs_pkg;
  // Strobes passed from the position tracker to the storage datapath
  typedef struct packed {
    logic wrEn;    // store the current pixel
    logic rowOdd;  // row parity: selects the bank
    logic wrSide;  // half of the double buffer being filled
  } wrStrobe_t;
endpackage

// File: rtl/rsfsBank.sv
module rsfsBank #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdDataA <= mem[rdAddrA];
    rdDataB <= mem[rdAddrB];
  end
endmodule

// File: rtl/rsfsControl.sv
module rsfsControl
  import rsfs_pkg::*;
#(
  parameter int COL_W = 5,
  parameter int ROW_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pixValid,
  input  logic                     newFrame,
  output wrStrobe_t                strobe,
  output logic [ROW_W-2+COL_W:0]   wrAddr,
  output logic                     readSide,
  output logic                     frameReady
);
  logic [COL_W-1:0] colCnt, effCol;
  logic [ROW_W-1:0] rowCnt, effRow;
  logic             wrSide;
  logic             lastPix;

  // a start pulse overrides the running position for the pixel beside it
  assign effCol  = newFrame ? '0 : colCnt;
  assign effRow  = newFrame ? '0 : rowCnt;
  assign lastPix = pixValid && (&effCol) && (&effRow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt     <= '0;
      rowCnt     <= '0;
      wrSide     <= 1'b0;
      frameReady <= 1'b0;
    end else if (pixValid) begin
      if (&effCol) begin
        colCnt <= '0;
        rowCnt <= effRow + 1'b1;
      end else begin
        colCnt <= effCol + 1'b1;
        rowCnt <= effRow;
      end
      if (lastPix) begin
        wrSide     <= ~wrSide;
        frameReady <= 1'b1;
      end
    end else if (newFrame) begin
      colCnt <= '0;
      rowCnt <= '0;
    end
  end

  always_comb begin
    strobe.wrEn   = pixValid;
    strobe.rowOdd = effRow[0];
    strobe.wrSide = wrSide;
  end

  assign wrAddr   = {effRow[ROW_W-1:1], effCol};
  assign readSide = ~wrSide;

  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameReady |=> frameReady);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pixValid && !newFrame) |=> ($stable(colCnt) && $stable(rowCnt)));

  p_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
    (newFrame && !pixValid) |=> (colCnt == '0 && rowCnt == '0));

  p_row_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !newFrame && (&colCnt)) |=>
      (colCnt == '0 && rowCnt == ROW_W'($past(rowCnt) + 1'b1)));

  p_side_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(pixValid && (&effCol) && (&effRow)) |=> $stable(readSide));
endmodule

// File: rtl/rsfsDatapath.sv
module rsfsDatapath
  import rsfs_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  input  logic              rdSide,
  input  logic [ADDR_W-1:0] rdAddrEvenA,
  input  logic [ADDR_W-1:0] rdAddrEvenB,
  input  logic [ADDR_W-1:0] rdAddrOddA,
  input  logic [ADDR_W-1:0] rdAddrOddB,
  output logic [PIX_W-1:0]  rdDataEvenA,
  output logic [PIX_W-1:0]  rdDataEvenB,
  output logic [PIX_W-1:0]  rdDataOddA,
  output logic [PIX_W-1:0]  rdDataOddB
);
  localparam int SIDES = 2;
  localparam int BANKS = 2;

  logic [PIX_W-1:0] bankQa [SIDES][BANKS];
  logic [PIX_W-1:0] bankQb [SIDES][BANKS];
  logic [SIDES*BANKS-1:0] bankWe;
  logic rdSideQ;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign bankWe[s*BANKS+b] = strobe.wrEn && (strobe.wrSide == 1'(s))
                                 && (strobe.rowOdd == 1'(b));
      rsfsBank #(.ADDR_W(ADDR_W), .DATA_W(PIX_W)) u_bank (
        .clk     (clk),
        .wrEn    (bankWe[s*BANKS+b]),
        .wrAddr  (wrAddr),
        .wrData  (wrData),
        .rdAddrA ((b == 0) ? rdAddrEvenA : rdAddrOddA),
        .rdAddrB ((b == 0) ? rdAddrEvenB : rdAddrOddB),
        .rdDataA (bankQa[s][b]),
        .rdDataB (bankQb[s][b])
      );
    end
  end

  // the side steering the output is the one seen with the address
  always_ff @(posedge clk) rdSideQ <= rdSide;

  assign rdDataEvenA = bankQa[rdSideQ][0];
  assign rdDataEvenB = bankQb[rdSideQ][0];
  assign rdDataOddA  = bankQa[rdSideQ][1];
  assign rdDataOddB  = bankQb[rdSideQ][1];

  p_single_bank_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankWe));

  p_no_write_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |-> (bankWe == '0));
endmodule

// File: rtl/rowSplitFrameStore.sv
module rowSplitFrameStore
  import rsfs_pkg::*;
#(
  parameter int COL_W = 5,
  parameter int ROW_W = 5,
  parameter int PIX_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pixValid,
  input  logic                   newFrame,
  input  logic [PIX_W-1:0]       pixData,
  input  logic [ROW_W-2+COL_W:0] rdAddrEvenA,
  input  logic [ROW_W-2+COL_W:0] rdAddrEvenB,
  input  logic [ROW_W-2+COL_W:0] rdAddrOddA,
  input  logic [ROW_W-2+COL_W:0] rdAddrOddB,
  output logic [PIX_W-1:0]       rdDataEvenA,
  output logic [PIX_W-1:0]       rdDataEvenB,
  output logic [PIX_W-1:0]       rdDataOddA,
  output logic [PIX_W-1:0]       rdDataOddB,
  output logic                   readSide,
  output logic                   frameReady
);
  localparam int ADDR_W = ROW_W - 1 + COL_W;

  wrStrobe_t         strobe;
  logic [ADDR_W-1:0] wrAddr;

  rsfsControl #(.COL_W(COL_W), .ROW_W(ROW_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pixValid   (pixValid),
    .newFrame   (newFrame),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .readSide   (readSide),
    .frameReady (frameReady)
  );

  rsfsDatapath #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrAddr      (wrAddr),
    .wrData      (pixData),
    .rdSide      (readSide),
    .rdAddrEvenA (rdAddrEvenA),
    .rdAddrEvenB (rdAddrEvenB),
    .rdAddrOddA  (rdAddrOddA),
    .rdAddrOddB  (rdAddrOddB),
    .rdDataEvenA (rdDataEvenA),
    .rdDataEvenB (rdDataEvenB),
    .rdDataOddA  (rdDataOddA),
    .rdDataOddB  (rdDataOddB)
  );
endmodule

// File: tb/rowSplitFrameStore_tb_top.sv
module rowSplitFrameStore_tb_top;
  localparam int COL_W  = 5;
  localparam int ROW_W  = 5;
  localparam int PIX_W  = 8;
  localparam int ADDR_W = ROW_W - 1 + COL_W;
  localparam int COLS   = 1 << COL_W;
  localparam int NPIX   = COLS << ROW_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN, pixValid, newFrame;
  logic [PIX_W-1:0] pixData;
  logic [ADDR_W-1:0] rdAddrEvenA, rdAddrEvenB, rdAddrOddA, rdAddrOddB;
  logic [PIX_W-1:0] rdDataEvenA, rdDataEvenB, rdDataOddA, rdDataOddB;
  logic readSide, frameReady;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rowSplitFrameStore #(.COL_W(COL_W), .ROW_W(ROW_W), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .newFrame(newFrame),
    .pixData(pixData),
    .rdAddrEvenA(rdAddrEvenA), .rdAddrEvenB(rdAddrEvenB),
    .rdAddrOddA(rdAddrOddA), .rdAddrOddB(rdAddrOddB),
    .rdDataEvenA(rdDataEvenA), .rdDataEvenB(rdDataEvenB),
    .rdDataOddA(rdDataOddA), .rdDataOddB(rdDataOddB),
    .readSide(readSide), .frameReady(frameReady)
  );

  function automatic logic [PIX_W-1:0] pv(int f, int r, int c);
    return PIX_W'((f * 61 + r * 29 + c * 7 + r * c) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic driveRead(int a);
    rdAddrEvenA = ADDR_W'(a);
    rdAddrOddA  = ADDR_W'(a);
    rdAddrEvenB = ADDR_W'((a + 1) % DEPTH);
    rdAddrOddB  = ADDR_W'((a + 1) % DEPTH);
  endtask

  // R4 R7: compare the four port outputs for address a against frame f
  task automatic checkRead(int a, int f, string req);
    int b = (a + 1) % DEPTH;
    int ok = 1;
    if (rdDataEvenA != pv(f, 2 * (a / COLS), a % COLS)) ok = 0;
    if (rdDataOddA  != pv(f, 2 * (a / COLS) + 1, a % COLS)) ok = 0;
    if (rdDataEvenB != pv(f, 2 * (b / COLS), b % COLS)) ok = 0;
    if (rdDataOddB  != pv(f, 2 * (b / COLS) + 1, b % COLS)) ok = 0;
    if (ok == 0)
      $display("FAIL %s addr %0d: actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               req, a, rdDataEvenA, rdDataOddA, rdDataEvenB, rdDataOddB,
               pv(f, 2 * (a / COLS), a % COLS), pv(f, 2 * (a / COLS) + 1, a % COLS),
               pv(f, 2 * (b / COLS), b % COLS), pv(f, 2 * (b / COLS) + 1, b % COLS));
    nRun++;
    if (ok == 0) nFail++;
  endtask

  task automatic readAll(int f, string req);
    for (int a = 0; a < DEPTH; a++) begin
      driveRead(a);
      @(negedge clk);
      checkRead(a, f, req);
    end
  endtask

  // stream npix pixels of frame f; optional idle gaps and concurrent reads of frame rf
  task automatic streamFrame(int f, int npix, bit mark, bit gaps, bit doRead, int rf);
    for (int k = 0; k < npix; k++) begin
      if (gaps && (k % 4 == 2)) begin
        pixValid = 1'b0;
        newFrame = 1'b0;
        pixData  = 8'hA5;   // R8: must not land anywhere
        @(negedge clk);
      end
      pixValid = 1'b1;
      newFrame = (mark && k == 0);
      pixData  = pv(f, k / COLS, k % COLS);
      if (doRead && k < DEPTH) driveRead(k);
      @(negedge clk);
      if (doRead && k < DEPTH) checkRead(k, rf, "R10");
      if (f == 10 && k == NPIX / 2) check("R6", int'(frameReady), 0);
    end
    pixValid = 1'b0;
    newFrame = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pixValid = 1'b0; newFrame = 1'b0; pixData = '0;
    driveRead(0);
    repeat (3) @(negedge clk);
    check("R1", int'(frameReady), 0);
    check("R1", int'(readSide), 1);
    rstN = 1'b1;
    @(negedge clk);

    // first frame: ready only after the last pixel, then side 0 readable
    streamFrame(10, NPIX, 1'b1, 1'b0, 1'b0, 0);
    check("R6", int'(frameReady), 1);
    check("R5", int'(readSide), 0);

    // second frame while reading the first (R3 R4 R7 R10)
    streamFrame(11, NPIX, 1'b1, 1'b0, 1'b1, 10);
    check("R5", int'(readSide), 1);
    readAll(11, "R3");

    // third frame with idle gaps and junk data
    streamFrame(12, NPIX, 1'b1, 1'b1, 1'b1, 11);
    check("R5", int'(readSide), 0);
    readAll(12, "R8");

    // partial frame, then a lone start pulse, then a full unmarked frame
    streamFrame(13, 100, 1'b1, 1'b0, 1'b0, 0);
    check("R9", int'(readSide), 0);
    readAll(12, "R10");
    newFrame = 1'b1;
    @(negedge clk);
    newFrame = 1'b0;
    check("R9", int'(readSide), 0);
    streamFrame(14, NPIX, 1'b0, 1'b0, 1'b0, 0);
    check("R2", int'(readSide), 1);
    readAll(14, "R2");

    // partial frame restarted by a start pulse that carries a pixel
    streamFrame(15, 50, 1'b1, 1'b0, 1'b0, 0);
    check("R9", int'(readSide), 1);
    streamFrame(16, NPIX, 1'b1, 1'b0, 1'b0, 0);
    check("R9", int'(readSide), 0);
    check("R6", int'(frameReady), 1);
    readAll(16, "R9");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule